// File: doc/BRIEF.md
# Serial Configuration Register Access Master

This block gives on-chip logic access to the configuration registers and statistics counters of an external Ethernet switch device. The device has a three-wire, bit-serial management port: a chip select, a serial clock and one bidirectional data line. A host hands the block one request at a time. The block frames the request as a serial command, drives and releases the data line, and returns the result.

Three operations are supported. A read of a 16-bit configuration register and a read of a 32-bit counter share one frame layout and differ only in a table-select bit. A write of a 16-bit configuration register uses a separate, shorter frame framed by chip select. Every bit travels most-significant first. The serial clock period comes from two parameters. `HALF_CLKS` is the number of system clocks in each clock phase, for example 600 for 3 µs at 200 MHz. `SETUP_CLKS` is the number of system clocks that outgoing data is held before each rising edge.

The request side follows a valid/ready handshake. A request is taken in a cycle where both `req_valid` and `req_ready` are high. `req_ready` stays low from that cycle until the operation completes, and any request offered in that time is not taken. The response side has no back-pressure. `rsp_valid` is a one-cycle pulse, and `rsp_rdata` keeps the last read result until the next read completes. When the block is idle, all three pins are released: every output enable is low.

Top module: `serial_cfg_master`

## Requirements
- R1: After reset, and again in the cycle `rsp_valid` pulses, `cs_oe`, `sk_oe` and `dio_oe` are low, `req_ready` is high and no serial clock edges occur.
- R2: A read sends 46 bits on `dio_o`, in this order: 32 ones, then 0,1,1,0, then the table bit (0 = configuration, 1 = counters), then 0,0, then `req_addr[6:0]` MSB first. `req_addr[7]` does not affect the frame, and `cs_o` stays low for the whole read.
- R3: A write sends 27 bits, in this order: 1,0,1, then `req_addr[7:0]`, then `req_wdata[15:0]`, each MSB first. `cs_o` is high at each of these 27 rising edges and falls together with the falling clock edge that follows the 27th bit.
- R4: Apart from the first bit of a frame, `sk_o` is low for `HALF_CLKS+SETUP_CLKS` cycles before each rise and high for `HALF_CLKS` cycles. `dio_o` holds its value for at least `SETUP_CLKS` cycles before each rising edge and does not change while `sk_o` is high.
- R5: After its 46th bit, a read lowers `dio_oe` at the next falling edge and keeps it low to the end of the frame. Rising edges 47 and 48 are turnaround. At rising edges 49 to 80 the block captures `dio_i`, first bit first, in the last system cycle before each rise.
- R6: Each frame ends with two trailing clocks after its last data bit, so a read has 82 rising edges and a write has 29. `sk_o` then stays low for `HALF_CLKS` cycles before the block goes idle.
- R7: A configuration read (table bit 0) returns the first 16 captured bits in `rsp_rdata[15:0]` when the address is odd, and the last 16 captured bits when it is even. Bits 31:16 are zero in both cases.
- R8: A counter read (table bit 1) returns all 32 captured bits, with the first captured bit in `rsp_rdata[31]`.
- R9: Each operation ends with exactly one single-cycle `rsp_valid` pulse. A write leaves `rsp_rdata` unchanged.
- R10: A request offered while `req_ready` is low is ignored: it changes neither the frame in progress nor the result, and it starts no later operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_table | input | 1 | Read table: 0 = configuration, 1 = counters |
| req_addr | input | 8 | Register or counter address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Last read result |
| cs_o | output | 1 | Chip select level |
| cs_oe | output | 1 | Chip select drive enable |
| sk_o | output | 1 | Serial clock level |
| sk_oe | output | 1 | Serial clock drive enable |
| dio_o | output | 1 | Outgoing serial data |
| dio_oe | output | 1 | Data line drive enable |
| dio_i | input | 1 | Incoming serial data |

## Verification
Configuration reads are run for all 256 addresses. This checks that the parity of the address alone chooses the returned half, and that bit 7 never reaches the frame. The device model sends back a 32-bit word whose halves and bytes are derived differently from the address, so a half taken from the wrong end, or bits in the wrong order, cannot match. Counter reads over a range of addresses separate the full-word path from the half-word path. Writes use all-zero, all-one, alternating and address-derived data, which show up a shift, a missing bit or a chip select that falls at the wrong edge. During every operation a stray request with different fields is offered, to show that it is ignored.

// File: rtl/scm_pkg.sv
package scm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PREP, ST_LOW, ST_SETUP, ST_HIGH, ST_FIN
  } scm_state_e;

  localparam int RD_FRAME_BITS = 46;
  localparam int WR_FRAME_BITS = 27;
  localparam int TURN_CLKS     = 2;
  localparam int RD_DATA_BITS  = 32;
  localparam int TAIL_CLKS     = 2;
  localparam int SHIFT_W       = RD_FRAME_BITS;

  localparam int RD_RECV_LO = RD_FRAME_BITS + TURN_CLKS;
  localparam int RD_RECV_HI = RD_RECV_LO + RD_DATA_BITS;
  localparam int RD_SLOTS   = RD_RECV_HI + TAIL_CLKS;
  localparam int WR_SLOTS   = WR_FRAME_BITS + TAIL_CLKS;
  localparam int SLOT_W     = $clog2(RD_SLOTS + 1);

  localparam logic [3:0] RD_OPCODE = 4'b0110;
  localparam logic [2:0] WR_OPCODE = 3'b101;
endpackage

// File: rtl/scm_phase_timer.sv
module scm_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/scm_shift_unit.sv
module scm_shift_unit
  import scm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [SHIFT_W-1:0] load_vec,
  input  logic               tx_step,
  input  logic               rx_step,
  input  logic               rx_bit,
  output logic               tx_bit,
  output logic [RD_DATA_BITS-1:0] rx_word
);
  logic [SHIFT_W-1:0] txq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txq    <= '0;
      tx_bit <= 1'b0;
    end else if (load) begin
      txq    <= load_vec;
      tx_bit <= 1'b0;
    end else if (tx_step) begin
      txq    <= {txq[SHIFT_W-2:0], 1'b0};
      tx_bit <= txq[SHIFT_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_word <= '0;
    else if (rx_step) rx_word <= {rx_word[RD_DATA_BITS-2:0], rx_bit};
  end

  // R5: capture and transmit never act in the same cycle
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_step |-> !tx_step && !load);
endmodule

// File: rtl/scm_sequencer.sv
module scm_sequencer
  import scm_pkg::*;
#(
  parameter int HALF_CLKS  = 600,
  parameter int SETUP_CLKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_rd,
  output logic busy,
  output logic sk,
  output logic cs,
  output logic dio_en,
  output logic tx_step,
  output logic rx_step,
  output logic finish
);
  localparam int LMAX = (HALF_CLKS > SETUP_CLKS) ? HALF_CLKS : SETUP_CLKS;
  localparam int TW   = $clog2(LMAX + 1);

  scm_state_e        state;
  logic              rd;
  logic [SLOT_W-1:0] slot;
  logic              tzero, tload, sending, recving, last;
  logic [TW-1:0]     tval;

  assign sending = rd ? (slot < SLOT_W'(RD_FRAME_BITS)) : (slot < SLOT_W'(WR_FRAME_BITS));
  assign recving = rd && (slot >= SLOT_W'(RD_RECV_LO)) && (slot < SLOT_W'(RD_RECV_HI));
  assign last    = rd ? (slot == SLOT_W'(RD_SLOTS - 1)) : (slot == SLOT_W'(WR_SLOTS - 1));

  assign tload = (state == ST_IDLE) ? start : tzero;
  assign tval  = (state == ST_LOW) ? TW'(SETUP_CLKS - 1) : TW'(HALF_CLKS - 1);

  scm_phase_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tload), .load_val(tval), .zero(tzero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rd    <= 1'b0;
      slot  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_PREP;
          rd    <= start_rd;
          slot  <= '0;
        end
        ST_PREP:  if (tzero) state <= ST_LOW;
        ST_LOW:   if (tzero) state <= ST_SETUP;
        ST_SETUP: if (tzero) state <= ST_HIGH;
        ST_HIGH:  if (tzero) begin
          if (last) state <= ST_FIN;
          else begin
            state <= ST_LOW;
            slot  <= slot + 1'b1;
          end
        end
        ST_FIN:   if (tzero) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state != ST_IDLE);
  assign sk      = (state == ST_HIGH);
  assign cs      = busy && !rd && (slot < SLOT_W'(WR_FRAME_BITS));
  assign dio_en  = busy && (!rd || (slot < SLOT_W'(RD_FRAME_BITS)));
  assign tx_step = (state == ST_LOW) && tzero && sending;
  assign rx_step = (state == ST_SETUP) && tzero && recving;
  assign finish  = (state == ST_FIN) && tzero;

  // R6: the slot index never runs past the frame length
  assert_slot_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd ? (slot < SLOT_W'(RD_SLOTS)) : (slot < SLOT_W'(WR_SLOTS))));
  // R4: a rising edge of sk always comes out of the setup phase
  assert_rise_after_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sk) |-> $past(state == ST_SETUP));
endmodule

// File: rtl/serial_cfg_master.sv
module serial_cfg_master
  import scm_pkg::*;
#(
  parameter int HALF_CLKS  = 600,
  parameter int SETUP_CLKS = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_read,
  input  logic        req_table,
  input  logic [7:0]  req_addr,
  input  logic [15:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        cs_o,
  output logic        cs_oe,
  output logic        sk_o,
  output logic        sk_oe,
  output logic        dio_o,
  output logic        dio_oe,
  input  logic        dio_i
);
  logic               busy, accept, tx_step, rx_step, finish;
  logic               rd_q, tbl_q, odd_q;
  logic [SHIFT_W-1:0] frame_vec;
  logic [RD_DATA_BITS-1:0] rx_word;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;

  assign frame_vec = req_read
    ? {{32{1'b1}}, RD_OPCODE, req_table, 2'b00, req_addr[6:0]}
    : {WR_OPCODE, req_addr, req_wdata, {(SHIFT_W - WR_FRAME_BITS){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      tbl_q <= 1'b0;
      odd_q <= 1'b0;
    end else if (accept) begin
      rd_q  <= req_read;
      tbl_q <= req_table;
      odd_q <= req_addr[0];
    end
  end

  scm_sequencer #(.HALF_CLKS(HALF_CLKS), .SETUP_CLKS(SETUP_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_rd(req_read),
    .busy(busy), .sk(sk_o), .cs(cs_o), .dio_en(dio_oe),
    .tx_step(tx_step), .rx_step(rx_step), .finish(finish)
  );

  scm_shift_unit u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_vec(frame_vec),
    .tx_step(tx_step), .rx_step(rx_step), .rx_bit(dio_i),
    .tx_bit(dio_o), .rx_word(rx_word)
  );

  assign cs_oe = busy;
  assign sk_oe = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= finish;
      if (finish && rd_q) begin
        if (tbl_q)      rsp_rdata <= rx_word;
        else if (odd_q) rsp_rdata <= {16'h0000, rx_word[31:16]};
        else            rsp_rdata <= {16'h0000, rx_word[15:0]};
      end
    end
  end

  // R1: every pin is released at completion
  assert_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !cs_oe && !sk_oe && !dio_oe && req_ready);
  // R2: chip select never rises during a read
  assert_cs_quiet_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q && !req_ready) |-> !cs_o);
  // R4: data is steady while the clock is high
  assert_dio_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sk_o && $past(sk_o)) |-> $stable(dio_o));
  // R4: data does not change at the rising edge itself
  assert_dio_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sk_o) |-> $stable(dio_o));
  // R5: the data line is released only in a read and only with the clock low
  assert_release_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dio_oe) && !rsp_valid && busy) |-> (!sk_o && rd_q));
  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R10: the latched request does not change while an operation runs
  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> ($stable(rd_q) && $stable(tbl_q) && $stable(odd_q)));
endmodule

// File: tb/test_serial_cfg_master.sv
`timescale 1ns/1ps
module test_serial_cfg_master;
  localparam int H = 2;
  localparam int S = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_read = 1'b0, req_table = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, cs_o, cs_oe, sk_o, sk_oe, dio_o, dio_oe, dio_i;
  logic [31:0] rsp_rdata;

  always #2.5 clk = ~clk;

  serial_cfg_master #(.HALF_CLKS(H), .SETUP_CLKS(S)) i_serial_cfg_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_table(req_table), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cs_o(cs_o), .cs_oe(cs_oe), .sk_o(sk_o), .sk_oe(sk_oe),
    .dio_o(dio_o), .dio_oe(dio_oe), .dio_i(dio_i)
  );

  int checks = 0, failures = 0;
  bit done_flag = 1'b0;

  // device model and edge monitor
  int   rise_cnt = 0, low_cnt = 0, hi_cnt = 0, since_fall = 0, age = 0;
  int   tim_viol = 0, setup_viol = 0;
  logic sk_q = 1'b0, dq = 1'b0;
  logic rec_d[128], rec_cs[128], rec_oe[128];
  logic cur_rd = 1'b0;
  logic [31:0] resp = '0;

  assign dio_i = (cur_rd && rise_cnt >= 48 && rise_cnt < 80) ? resp[79 - rise_cnt] : 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sk_o && !sk_q) begin
        rec_d[rise_cnt]  <= dio_o;
        rec_cs[rise_cnt] <= cs_o;
        rec_oe[rise_cnt] <= dio_oe;
        if (rise_cnt > 0 && low_cnt != H + S) tim_viol <= tim_viol + 1;
        if (dio_o != dq || age + 1 < S) setup_viol <= setup_viol + 1;
        rise_cnt <= rise_cnt + 1;
      end else if (rsp_valid) begin
        rise_cnt <= 0;
      end
      if (!sk_o && sk_q) begin
        if (hi_cnt != H) tim_viol <= tim_viol + 1;
        since_fall <= 0;
      end else begin
        since_fall <= since_fall + 1;
      end
      if (sk_o && sk_q && dio_o != dq) setup_viol <= setup_viol + 1;
      low_cnt <= sk_o ? 0 : low_cnt + 1;
      hi_cnt  <= sk_o ? hi_cnt + 1 : 0;
      age     <= (dio_o != dq) ? 0 : age + 1;
      sk_q    <= sk_o;
      dq      <= dio_o;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input bit rd, input bit tbl, input logic [7:0] addr,
                     input logic [15:0] wd, input logic [31:0] pat);
    logic [45:0] exp_rd;
    logic [26:0] exp_wr;
    logic [31:0] exp_data, prev_rdata;
    int nrise, bad_bit, bad_cs, bad_oe, tv0, sv0, pulses, waited, sf;
    bit stray_done;
    tv0 = tim_viol; sv0 = setup_viol;
    prev_rdata = rsp_rdata;
    exp_rd = {32'hFFFF_FFFF, 4'b0110, tbl, 2'b00, addr[6:0]};
    exp_wr = {3'b101, addr, wd};
    @(negedge clk);
    cur_rd = rd; resp = pat;
    req_read = rd; req_table = tbl; req_addr = addr; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    stray_done = 1'b0; pulses = 0; waited = 0; nrise = 0; sf = 0;
    while (pulses == 0 && waited < 2000) begin
      @(negedge clk);
      waited++;
      if (!stray_done && rise_cnt == 10) begin
        req_read = !rd; req_table = !tbl; req_addr = ~addr; req_wdata = ~wd;
        req_valid = 1'b1;
        stray_done = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      if (rsp_valid) begin
        pulses++; nrise = rise_cnt; sf = since_fall;
      end
    end
    req_valid = 1'b0;
    chk(pulses == 1, "R9", "completion pulse seen", pulses, 1);
    chk(!cs_oe && !sk_oe && !dio_oe && req_ready, "R1", "pins released at completion",
        {cs_oe, sk_oe, dio_oe, req_ready}, 4'b0001);
    chk(nrise == (rd ? 82 : 29), "R6", "rising edge count", nrise, rd ? 82 : 29);
    chk(sf + 1 == H, "R6", "final low phase length", sf + 1, H);
    chk(tim_viol == tv0, "R4", "clock phase lengths", tim_viol - tv0, 0);
    chk(setup_viol == sv0, "R4", "data setup and hold", setup_viol - sv0, 0);
    bad_bit = -1; bad_cs = -1; bad_oe = -1;
    if (rd) begin
      for (int k = 0; k < 46; k++) if (rec_d[k] !== exp_rd[45 - k] && bad_bit < 0) bad_bit = k;
      for (int k = 0; k < 82; k++) if (rec_cs[k] !== 1'b0 && bad_cs < 0) bad_cs = k;
      for (int k = 0; k < 82; k++) if (rec_oe[k] !== (k < 46) && bad_oe < 0) bad_oe = k;
      chk(bad_bit < 0, "R2", "read frame first bad bit", bad_bit, -1);
      chk(bad_cs < 0, "R2", "chip select during read", bad_cs, -1);
      chk(bad_oe < 0, "R5", "data line release at turnaround", bad_oe, -1);
      exp_data = tbl ? pat : (addr[0] ? {16'h0, pat[31:16]} : {16'h0, pat[15:0]});
      if (tbl) chk(rsp_rdata == exp_data, "R8", "counter read data", rsp_rdata, exp_data);
      else     chk(rsp_rdata == exp_data, "R7", "config read halfword", rsp_rdata, exp_data);
    end else begin
      for (int k = 0; k < 27; k++) if (rec_d[k] !== exp_wr[26 - k] && bad_bit < 0) bad_bit = k;
      for (int k = 0; k < 29; k++) if (rec_cs[k] !== (k < 27) && bad_cs < 0) bad_cs = k;
      for (int k = 0; k < 29; k++) if (rec_oe[k] !== 1'b1 && bad_oe < 0) bad_oe = k;
      chk(bad_bit < 0, "R3", "write frame first bad bit", bad_bit, -1);
      chk(bad_cs < 0, "R3", "chip select during write", bad_cs, -1);
      chk(bad_oe < 0, "R3", "data line driven in write", bad_oe, -1);
      chk(rsp_rdata == prev_rdata, "R9", "rdata kept after write", rsp_rdata, prev_rdata);
    end
    // R10: the stray request must not start another operation
    pulses = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (rsp_valid || sk_o || sk_oe) pulses++;
    end
    chk(pulses == 0 && rise_cnt == 0 && req_ready, "R10", "no activity after stray request",
        pulses, 0);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!done_flag) begin
      failures++;
      $display("FAIL watchdog run did not finish actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R1", "ready after reset", {req_ready, rsp_valid}, 2'b10);
    chk(!cs_oe && !sk_oe && !dio_oe, "R1", "pins released after reset",
        {cs_oe, sk_oe, dio_oe}, 3'b000);
    chk(rsp_rdata == 32'h0, "R1", "rdata after reset", rsp_rdata, 0);
    for (int a = 0; a < 256; a++)
      run(1'b1, 1'b0, 8'(a), 16'h0,
          {8'(a), 8'(a) ^ 8'hA5, ~8'(a), 8'(a * 3) ^ 8'h3C});
    for (int a = 0; a < 16; a++)
      run(1'b1, 1'b1, 8'(a * 7 + 1), 16'h0, {8'(a) ^ 8'h96, 8'h0F, ~8'(a), 8'(a * 5) + 8'h11});
    run(1'b0, 1'b0, 8'h00, 16'h0000, 32'h0);
    run(1'b0, 1'b0, 8'hFF, 16'hFFFF, 32'h0);
    run(1'b0, 1'b0, 8'hAA, 16'h5555, 32'h0);
    run(1'b0, 1'b0, 8'h55, 16'hAAAA, 32'h0);
    for (int a = 0; a < 24; a++)
      run(1'b0, 1'b0, 8'(a * 11), {8'(a), ~8'(a * 9)}, 32'h0);
    done_flag = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule